// File: doc/BRIEF.md
# Framed Serializer with Calibration Gating

This block turns fixed-width parallel words into a single serial line, one bit per transmit clock cycle. After reset is released it runs a calibration interval of a configurable number of cycles; during that time the line is held low and the line-enable status stays low. When calibration ends, the enable status rises and the first word is taken from the parallel input on that same clock edge. From then on a new word is captured every `DATA_W` cycles, always on the edge that follows the last bit of the previous word, so the line carries a continuous, gap-free stream.

Every captured word must carry two marker bits so that the receiver can find word boundaries: the lowest bit must be 1 and the highest bit must be 0. A captured word that breaks this rule sets a sticky violation flag that only reset clears. Input values that are present on edges where no word is captured are ignored. The shift order (lowest bit first by default) and the word that fills the shift register at reset are parameters; that fill word is checked at elaboration to obey the marker rule.

Top module: `framed_serializer`

## Requirements
- R1: While `rst` is high, `line_en`, `ser_out` and `frame_viol` are all 0.
- R2: After `rst` falls, `line_en` rises on exactly the `CAL_CYCLES`-th rising clock edge (default 2400) and then stays at 1 until the next reset.
- R3: While `line_en` is 0, `ser_out` is 0 whatever value `par_in` has.
- R4: The edge on which `line_en` rises also captures `par_in`; in the cycle after that edge `ser_out` carries bit 0 of the captured word.
- R5: With the default lowest-bit-first order, the captured word leaves on `ser_out` one bit per cycle, bit 0 through bit 11; the next word is captured on the edge after bit 11 is shown, giving a period of exactly 12 cycles with no idle cycle between words.
- R6: If a captured word has bit 0 equal to 0 or bit 11 equal to 1, `frame_viol` is 1 from the cycle after the capturing edge and stays 1 until reset.
- R7: Values on `par_in` during calibration and on edges that do not capture a word change neither `ser_out` nor `frame_viol`.
- R8: Asserting `rst` in the middle of a word clears `frame_viol` and `line_en`, and a full calibration interval is run again before any bit is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | DATA_W (12) | Parallel word to send; bit 0 must be 1 and bit DATA_W-1 must be 0 |
| ser_out | output | 1 | Serial line output, held at 0 until calibration ends |
| line_en | output | 1 | High once calibration has ended and the line carries data |
| frame_viol | output | 1 | Sticky flag: a captured word broke the marker rule |

## Verification
The hardest situation to reach is the boundary between calibration and transmission: the first capture happens on the very edge that raises `line_en`, and a marker violation in that first word must set the flag at once while all the junk seen earlier is ignored. The stimulus gets there by counting edges from reset release and placing a chosen word on `par_in` just before the `CAL_CYCLES`-th edge, once with a legal word and, after a reset in the middle of a word, once with an illegal one. Between capture edges `par_in` is filled with random values that often break the marker rule, so any capture outside the word boundary shows up as a wrong bit or a false flag.

// File: rtl/ser_pkg.sv
package ser_pkg;

   typedef enum logic {
      ORDER_LSB = 1'b0,
      ORDER_MSB = 1'b1
   } bit_order_e;

endpackage

// File: rtl/ser_cal_timer.sv
module ser_cal_timer #(
   parameter int unsigned CAL_CYCLES = 2400
) (
   input  logic clk,
   input  logic rst,
   output logic cal_last,
   output logic cal_done
);

   localparam int unsigned CNT_W    = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CAL_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   generate
      if (CAL_CYCLES < 1) begin : g_bad_len
         $error("ser_cal_timer: CAL_CYCLES must be at least 1");
      end
   endgenerate

   // Edge k after reset release leaves cnt_q at k; the edge that finds
   // LAST_CNT ends calibration, i.e. edge number CAL_CYCLES.
   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         if (cnt_q == LAST_CNT) begin
            done_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cal_last = !done_q && (cnt_q == LAST_CNT);
   assign cal_done = done_q;

endmodule

// File: rtl/ser_shift_unit.sv
module ser_shift_unit
   import ser_pkg::*;
#(
   parameter int unsigned         DATA_W    = 12,
   parameter bit_order_e          ORDER     = ORDER_LSB,
   parameter logic [DATA_W-1:0]   FILL_WORD = 12'h0AB
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              run,
   input  logic [DATA_W-1:0] word_in,
   output logic              capture,
   output logic              bit_out
);

   localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] sh_next;
   logic [IDX_W-1:0]  idx_q;

   // The index rests on LAST_IDX while idle, so the first edge with run
   // high captures a word.
   assign capture = run && (idx_q == LAST_IDX);

   generate
      if (ORDER == ORDER_LSB) begin : g_lsb
         assign bit_out = sh_q[0];
         assign sh_next = {1'b0, sh_q[DATA_W-1:1]};
      end else begin : g_msb
         assign bit_out = sh_q[DATA_W-1];
         assign sh_next = {sh_q[DATA_W-2:0], 1'b0};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q  <= FILL_WORD;
         idx_q <= LAST_IDX;
      end else if (capture) begin
         sh_q  <= word_in;
         idx_q <= '0;
      end else if (run) begin
         sh_q  <= sh_next;
         idx_q <= idx_q + 1'b1;
      end
   end

endmodule

// File: rtl/ser_frame_check.sv
module ser_frame_check #(
   parameter int unsigned DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              capture,
   input  logic [DATA_W-1:0] word_in,
   output logic              viol
);

   logic marker_ok;
   logic viol_q;

   assign marker_ok = word_in[0] && !word_in[DATA_W-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         viol_q <= 1'b0;
      end else if (capture && !marker_ok) begin
         viol_q <= 1'b1;
      end
   end

   assign viol = viol_q;

endmodule

// File: rtl/framed_serializer.sv
module framed_serializer
   import ser_pkg::*;
#(
   parameter int unsigned       DATA_W     = 12,
   parameter int unsigned       CAL_CYCLES = 2400,
   parameter bit_order_e        ORDER      = ORDER_LSB,
   parameter logic [DATA_W-1:0] IDLE_WORD  = 12'h0AB
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] par_in,
   output logic              ser_out,
   output logic              line_en,
   output logic              frame_viol
);

   logic cal_last;
   logic cal_done;
   logic run;
   logic capture;
   logic raw_bit;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("framed_serializer: DATA_W must be at least 2");
      end
      if (!(IDLE_WORD[0] && !IDLE_WORD[DATA_W-1])) begin : g_bad_idle
         $error("framed_serializer: IDLE_WORD breaks the marker rule");
      end
   endgenerate

   ser_cal_timer #(
      .CAL_CYCLES (CAL_CYCLES)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .cal_last (cal_last),
      .cal_done (cal_done)
   );

   // The shifter starts on the edge that ends calibration.
   assign run = cal_last || cal_done;

   ser_shift_unit #(
      .DATA_W    (DATA_W),
      .ORDER     (ORDER),
      .FILL_WORD (IDLE_WORD)
   ) u_shift (
      .clk     (clk),
      .rst     (rst),
      .run     (run),
      .word_in (par_in),
      .capture (capture),
      .bit_out (raw_bit)
   );

   ser_frame_check #(
      .DATA_W (DATA_W)
   ) u_check (
      .clk     (clk),
      .rst     (rst),
      .capture (capture),
      .word_in (par_in),
      .viol    (frame_viol)
   );

   assign line_en = cal_done;
   assign ser_out = cal_done & raw_bit;

endmodule

// File: rtl/ser_chk.sv
module ser_chk #(
   parameter int unsigned DATA_W     = 12,
   parameter int unsigned CAL_CYCLES = 2400
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] par_in,
   input logic              ser_out,
   input logic              line_en,
   input logic              frame_viol
);

   logic [31:0] since_rst;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_rst <= '0;
      end else if (since_rst != 32'hFFFF_FFFF) begin
         since_rst <= since_rst + 1;
      end
   end

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (!line_en && !ser_out && !frame_viol));

   assert_cal_length_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(line_en) |-> (since_rst == CAL_CYCLES));

   assert_en_holds_R2: assert property (@(posedge clk) disable iff (rst)
      line_en |=> line_en);

   assert_quiet_line_R3: assert property (@(posedge clk) disable iff (rst)
      !line_en |-> !ser_out);

   assert_viol_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      frame_viol |=> frame_viol);

   assert_viol_after_cal_R7: assert property (@(posedge clk) disable iff (rst)
      frame_viol |-> line_en);

endmodule

bind framed_serializer ser_chk #(
   .DATA_W     (DATA_W),
   .CAL_CYCLES (CAL_CYCLES)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .par_in     (par_in),
   .ser_out    (ser_out),
   .line_en    (line_en),
   .frame_viol (frame_viol)
);

// File: tb/sim_framed_serializer.sv
module sim_framed_serializer;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 12;
   localparam int CAL        = 2400;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] par_in = '0;
   logic         ser_out;
   logic         line_en;
   logic         frame_viol;

   int  total = 0;
   int  bad   = 0;
   bit  exp_viol = 1'b0;
   logic [W-1:0] cur;

   always #(CLK_PERIOD/2) clk = ~clk;

   framed_serializer u0 (
      .clk        (clk),
      .rst        (rst),
      .par_in     (par_in),
      .ser_out    (ser_out),
      .line_en    (line_en),
      .frame_viol (frame_viol)
   );

   function automatic bit marker_ok(input logic [W-1:0] w);
      return w[0] && !w[W-1];
   endfunction

   function automatic logic [W-1:0] good_word();
      return (W'($urandom) & 12'h7FE) | 12'h001;
   endfunction

   function automatic logic [W-1:0] junk_word();
      return W'($urandom);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // Runs the calibration interval; first is placed on par_in just
   // before the edge that ends it (R4).
   task automatic calibrate(input logic [W-1:0] first);
      for (int i = 1; i <= CAL; i++) begin
         par_in = (i == CAL) ? first : junk_word();
         @(negedge clk);
         if (i < CAL) begin
            if (i % 100 == 1 || i == CAL - 1) begin
               check("R2 line_en during calibration", line_en, 0);
               check("R3 ser_out during calibration", ser_out, 0);
               check("R7 frame_viol during calibration", frame_viol, 0);
            end else if (ser_out !== 1'b0 || line_en !== 1'b0 || frame_viol !== 1'b0) begin
               check("R3 quiet line during calibration",
                     {ser_out, line_en, frame_viol}, 0);
            end
         end else begin
            check("R2 line_en at end of calibration", line_en, 1);
            check("R4 first bit right after capture", ser_out, first[0]);
            if (!marker_ok(first)) exp_viol = 1'b1;
            check("R6 flag after first capture", frame_viol, exp_viol);
         end
      end
      cur = first;
   endtask

   // Sends n further words; word number bad_idx breaks the marker rule.
   task automatic stream(input int n, input int bad_idx, input logic [W-1:0] bad_w);
      for (int k = 0; k < n; k++) begin
         logic [W-1:0] nxt;
         for (int b = 1; b < W; b++) begin
            par_in = junk_word();
            @(negedge clk);
            check("R5 serial bit order", ser_out, cur[b]);
            check("R7 junk between captures ignored", frame_viol, exp_viol);
            check("R2 line_en stays high", line_en, 1);
         end
         nxt = (k == bad_idx) ? bad_w : good_word();
         if (k == 1) nxt = 12'h001;
         if (k == 2) nxt = 12'h7FF;
         par_in = nxt;
         @(negedge clk);
         check("R5 next word starts without gap", ser_out, nxt[0]);
         if (!marker_ok(nxt)) exp_viol = 1'b1;
         check("R6 marker violation flag", frame_viol, exp_viol);
         cur = nxt;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   initial begin
      void'($urandom(32'd1234));
      rst = 1'b1;
      par_in = junk_word();
      repeat (3) @(negedge clk);
      check("R1 line_en in reset", line_en, 0);
      check("R1 ser_out in reset", ser_out, 0);
      check("R1 frame_viol in reset", frame_viol, 0);

      rst = 1'b0;
      calibrate(good_word() | 12'h001);
      stream(40, 20, 12'hFFF);
      check("R6 flag sticky after bad word", frame_viol, 1);

      // Reset in the middle of a word (R8).
      repeat (5) begin
         par_in = junk_word();
         @(negedge clk);
      end
      rst = 1'b1;
      @(negedge clk);
      check("R8 line_en cleared by reset", line_en, 0);
      check("R8 frame_viol cleared by reset", frame_viol, 0);
      check("R8 ser_out low in reset", ser_out, 0);
      exp_viol = 1'b0;
      rst = 1'b0;

      // First word after calibration breaks the marker rule (R6, R4).
      calibrate(12'h000);
      stream(20, -1, 12'h000);
      check("R6 flag held after boundary violation", frame_viol, 1);
      summary();
   end

endmodule